// File: doc/BRIEF.md
# Segmented Virtual Address Translator

This block sits between a CPU with a 24-bit address bus and physical RAM. It maps CPU addresses to RAM addresses through a segment table held in an external 16K-byte RAM. Memory is cut into 32 kB segments, 128 of them per address space. A 7-bit address-space number, joined with CPU address bits 21..15, selects one table byte. The low seven bits of that byte give the physical segment number, and bit 7 marks the segment as read-only. The value 8'h80 is reserved to mean that no segment is mapped.

The block also polices each bus cycle. It blocks RAM writes into read-only segments. It can refuse instruction fetches from writable segments. It rejects accesses above the 4 MB RAM boundary while the CPU runs in user mode. It flags accesses to unmapped segments. Every fault can raise a one-cycle abort in the same cycle as the bus access, and the 2-bit cause is kept for software to read.

Two registers sit in CPU space: the address-space number at 24'hF88000 and the control register at 24'hF88001. Virtual mode is off after reset, so boot code runs on real addresses. DMA cycles always use real addresses.

Top module: `seg_translator`

## Requirements
- R1: After reset, virtual mode is off, both registers read 0, and ramAddr equals cpuAddr.
- R2: The address-space register at 24'hF88000 stores bits 6..0 and reads bit 7 as 0. The control register at 24'hF88001 stores bits 7,6,5,4,1,0. Its bits 3..2 read back the latched abort cause, and writes to them are ignored. Control bit 7 enables virtual mode, bit 4 enables abort, bit 1 forbids fetches from writable segments, and bit 0 selects user mode.
- R3: In virtual mode, for a CPU address below 4 MB, the table index is {asid, cpuAddr[21:15]}. ramAddr is {2'b00, entry[6:0], cpuAddr[14:0]}.
- R4: When virtual mode is off, or dmaActive is high, ramAddr equals cpuAddr, ramWe equals cpuValid and cpuWrite, and abort stays low.
- R5: A write to a segment whose entry has bit 7 set leaves ramWe low. With abort enabled, it raises abort with cause 1.
- R6: Any access to a segment whose entry is 8'h80 raises abort with cause 3, and ramWe stays low.
- R7: With control bit 1 set, an opcode fetch from a segment with entry bit 7 clear raises abort with cause 2. A fetch from a read-only segment raises no abort.
- R8: In user mode, an access at or above 4 MB raises abort with cause 0 and leaves ramWe low. A register write made this way is ignored.
- R9: In system mode, an access at or above 4 MB passes through untranslated and raises no abort.
- R10: With abort disabled, faults still block writes, but abort stays low and the latched cause does not change.
- R11: Abort is high only in the faulting cycle. The cause is latched at the end of that cycle and held until the next abort.
- R12: When faults coincide, the cause reported is chosen in this order: invalid segment, then beyond-RAM, then write-protect, then execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 24 | CPU address |
| cpuWrData | input | 8 | CPU write data |
| cpuValid | input | 1 | Bus cycle active |
| cpuWrite | input | 1 | Bus cycle is a write |
| opFetch | input | 1 | Bus cycle is an opcode fetch |
| dmaActive | input | 1 | Current cycle is a DMA cycle |
| tblIdx | output | 14 | Segment table lookup index |
| tblEntry | input | 8 | Table byte at tblIdx (asynchronous read) |
| ramAddr | output | 24 | Physical address |
| ramWe | output | 1 | Gated RAM write enable |
| abort | output | 1 | Abort pulse for the current bus cycle |
| regRdData | output | 8 | Register read data |

## Verification
Two pairs of functions can fall in the same cycle. In the first pair, a write to a segment marked 8'h80 is both an invalid access and a write to a read-only segment. The bench provokes it and then reads the control register, expecting cause 3. In the second pair, a DMA cycle or a system-mode access above 4 MB lands on a faulting address while virtual mode is on. The bench expects the address unchanged and no abort. A behavioural model in the bench tracks the registers and the latched cause and is compared against every output on every cycle.

// File: rtl/seg_translator_pkg.sv
package seg_translator_pkg;
  localparam int CB_VM     = 7;
  localparam int CB_ABORT  = 4;
  localparam int CB_NOEXEC = 1;
  localparam int CB_USER   = 0;
  localparam logic [7:0] CTRL_WMASK = 8'hF3;
  localparam logic [7:0] ENTRY_INVALID = 8'h80;

  typedef enum logic [1:0] {
    RSN_BEYOND  = 2'd0,
    RSN_WPROT   = 2'd1,
    RSN_EXEC    = 2'd2,
    RSN_INVALID = 2'd3
  } abortRsnT;

  typedef struct packed {
    logic translate;
    logic passWrite;
    logic abort;
  } mmuStrobeT;
endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_translator_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int RAM_BITS = 22,
  parameter int ASID_W   = 7,
  parameter logic [ADDR_W-1:0] ASID_REG = 24'hF88000,
  parameter logic [ADDR_W-1:0] CTRL_REG = 24'hF88001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuValid,
  input  logic              cpuWrite,
  input  logic              opFetch,
  input  logic              dmaActive,
  input  logic [7:0]        tblEntry,
  output mmuStrobeT         strobe,
  output logic [ASID_W-1:0] asid,
  output logic [7:0]        ctrlView
);
  localparam int HI_W = ADDR_W - RAM_BITS;

  logic [7:0]  ctrlQ;
  abortRsnT    rsnQ, rsnNext;
  logic        vmOn, inRam, translate;
  logic        fInvalid, fBeyond, fWprot, fExec, anyFault, abortNow, regWr;

  always_comb begin
    vmOn      = ctrlQ[CB_VM] && !dmaActive;
    inRam     = (cpuAddr[ADDR_W-1:RAM_BITS] == {HI_W{1'b0}});
    translate = vmOn && inRam;
    fInvalid  = cpuValid && translate && (tblEntry == ENTRY_INVALID);
    fBeyond   = cpuValid && vmOn && ctrlQ[CB_USER] && !inRam;
    fWprot    = cpuValid && translate && tblEntry[7] && cpuWrite;
    fExec     = cpuValid && translate && ctrlQ[CB_NOEXEC] && opFetch && !tblEntry[7];
    anyFault  = fInvalid || fBeyond || fWprot || fExec;
    abortNow  = anyFault && ctrlQ[CB_ABORT];
    regWr     = cpuValid && cpuWrite && !fBeyond;
  end

  always_comb begin
    if (fInvalid)     rsnNext = RSN_INVALID;
    else if (fBeyond) rsnNext = RSN_BEYOND;
    else if (fWprot)  rsnNext = RSN_WPROT;
    else              rsnNext = RSN_EXEC;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= 8'h00;
      asid  <= '0;
      rsnQ  <= RSN_BEYOND;
    end else begin
      if (regWr && cpuAddr == CTRL_REG) ctrlQ <= cpuWrData & CTRL_WMASK;
      if (regWr && cpuAddr == ASID_REG) asid  <= cpuWrData[ASID_W-1:0];
      if (abortNow) rsnQ <= rsnNext;
    end
  end

  always_comb begin
    strobe.translate = translate;
    strobe.passWrite = cpuValid && cpuWrite && !anyFault;
    strobe.abort     = abortNow;
    ctrlView         = {ctrlQ[7:4], rsnQ, ctrlQ[1:0]};
  end

  // R11
  reason_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.abort) |-> $stable(ctrlView[3:2]));

  // R12
  invalid_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.abort && strobe.translate && tblEntry == ENTRY_INVALID) |=> ctrlView[3:2] == 2'd3);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> ctrlView == 8'h00);
endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_translator_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 15,
  parameter int SEG_W  = 7,
  parameter int ASID_W = 7,
  parameter logic [ADDR_W-1:0] ASID_REG = 24'hF88000,
  parameter logic [ADDR_W-1:0] CTRL_REG = 24'hF88001
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  mmuStrobeT               strobe,
  input  logic [ASID_W-1:0]       asid,
  input  logic [7:0]              ctrlView,
  input  logic [7:0]              tblEntry,
  output logic [ASID_W+SEG_W-1:0] tblIdx,
  output logic [ADDR_W-1:0]       ramAddr,
  output logic                    ramWe,
  output logic                    abort,
  output logic [7:0]              regRdData
);
  localparam int RAM_BITS = OFF_W + SEG_W;
  localparam int HI_W     = ADDR_W - RAM_BITS;

  always_comb begin
    tblIdx = {asid, cpuAddr[RAM_BITS-1:OFF_W]};
    if (strobe.translate)
      ramAddr = {{HI_W{1'b0}}, tblEntry[SEG_W-1:0], cpuAddr[OFF_W-1:0]};
    else
      ramAddr = cpuAddr;
    ramWe = strobe.passWrite;
    abort = strobe.abort;
    if (cpuAddr == ASID_REG)      regRdData = 8'(asid);
    else if (cpuAddr == CTRL_REG) regRdData = ctrlView;
    else                          regRdData = 8'h00;
  end

  // R3
  low_ram_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.translate |-> ramAddr[ADDR_W-1:RAM_BITS] == {HI_W{1'b0}});
endmodule

// File: rtl/seg_translator.sv
module seg_translator
  import seg_translator_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int OFF_W  = 15,
  parameter int SEG_W  = 7,
  parameter int ASID_W = 7,
  parameter logic [ADDR_W-1:0] ASID_REG = 24'hF88000,
  parameter logic [ADDR_W-1:0] CTRL_REG = 24'hF88001
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [7:0]              cpuWrData,
  input  logic                    cpuValid,
  input  logic                    cpuWrite,
  input  logic                    opFetch,
  input  logic                    dmaActive,
  output logic [ASID_W+SEG_W-1:0] tblIdx,
  input  logic [7:0]              tblEntry,
  output logic [ADDR_W-1:0]       ramAddr,
  output logic                    ramWe,
  output logic                    abort,
  output logic [7:0]              regRdData
);
  localparam int RAM_BITS = OFF_W + SEG_W;

  mmuStrobeT         strobe;
  logic [ASID_W-1:0] asid;
  logic [7:0]        ctrlView;

  seg_ctrl #(
    .ADDR_W(ADDR_W), .RAM_BITS(RAM_BITS), .ASID_W(ASID_W),
    .ASID_REG(ASID_REG), .CTRL_REG(CTRL_REG)
  ) ctrlU (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuValid(cpuValid), .cpuWrite(cpuWrite), .opFetch(opFetch),
    .dmaActive(dmaActive), .tblEntry(tblEntry), .strobe(strobe),
    .asid(asid), .ctrlView(ctrlView)
  );

  seg_datapath #(
    .ADDR_W(ADDR_W), .OFF_W(OFF_W), .SEG_W(SEG_W), .ASID_W(ASID_W),
    .ASID_REG(ASID_REG), .CTRL_REG(CTRL_REG)
  ) dpU (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .strobe(strobe), .asid(asid),
    .ctrlView(ctrlView), .tblEntry(tblEntry), .tblIdx(tblIdx),
    .ramAddr(ramAddr), .ramWe(ramWe), .abort(abort), .regRdData(regRdData)
  );

  // R4
  dma_real_chk: assert property (@(posedge clk) disable iff (!rstN)
    dmaActive |-> (ramAddr == cpuAddr && !abort));

  // R5
  wprot_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.translate && cpuWrite && tblEntry[7]) |-> !ramWe);
endmodule

// File: tb/seg_translator_test.sv
module seg_translator_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic        cpuValid = 1'b0, cpuWrite = 1'b0, opFetch = 1'b0, dmaActive = 1'b0;
  logic [13:0] tblIdx;
  logic [7:0]  tblEntry;
  logic [23:0] ramAddr;
  logic        ramWe, abort;
  logic [7:0]  regRdData;

  logic [7:0] tbl [16384];
  int vectors = 0, errors = 0;
  int mAsid = 0, mCtrl = 0, mRsn = 0;

  always #2 clk = ~clk;
  assign tblEntry = tbl[tblIdx];

  seg_translator uut (.*);

  task automatic doReset();
    rstN = 1'b0; cpuValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mAsid = 0; mCtrl = 0; mRsn = 0;
  endtask

  task automatic step(input logic [23:0] a, input logic [7:0] wd, input bit v, w, f, d,
                      input string tag);
    int ent, eAddr, eRd, nAsid, nCtrl, nRsn;
    bit vm, low, fault, beyond, inv, wp, ex, eWe, eAb;
    @(negedge clk);
    cpuAddr = a; cpuWrData = wd; cpuValid = v; cpuWrite = w; opFetch = f; dmaActive = d;
    #1;
    ent    = tbl[mAsid * 128 + int'(a[21:15])];
    vm     = mCtrl[7] && !d;
    low    = a < 24'h400000;
    inv    = v && vm && low && ent == 8'h80;
    beyond = v && vm && !low && mCtrl[0];
    wp     = v && vm && low && ent[7] && w;
    ex     = v && vm && low && mCtrl[1] && f && !ent[7];
    fault  = inv || beyond || wp || ex;
    eAb    = fault && mCtrl[4];
    eWe    = v && w && !fault;
    eAddr  = (vm && low) ? (ent % 128) * 32768 + int'(a[14:0]) : int'(a);
    eRd    = (a == 24'hF88000) ? mAsid :
             (a == 24'hF88001) ? (mCtrl + mRsn * 4) : 0;
    vectors++;
    if (ramAddr !== 24'(eAddr) || ramWe !== eWe || abort !== eAb || regRdData !== 8'(eRd)) begin
      errors++;
      $display("FAIL %s addr=%h: got ramAddr=%h we=%b abort=%b rd=%h, expected %h %b %b %h",
               tag, a, ramAddr, ramWe, abort, regRdData, 24'(eAddr), eWe, eAb, 8'(eRd));
    end
    nAsid = mAsid; nCtrl = mCtrl; nRsn = mRsn;
    if (v && w && !beyond && a == 24'hF88000) nAsid = wd % 128;
    if (v && w && !beyond && a == 24'hF88001) nCtrl = wd & 8'hF3;
    if (eAb) nRsn = inv ? 3 : beyond ? 0 : wp ? 1 : 2;
    @(posedge clk);
    mAsid = nAsid; mCtrl = nCtrl; mRsn = nRsn;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16384; i++) tbl[i] = 8'((i * 37 + 5) % 127);
    tbl[5*128+0] = 8'h11; tbl[5*128+1] = 8'h93;
    tbl[5*128+2] = 8'h80; tbl[5*128+3] = 8'h05;
    doReset();
    // R1 reset state
    step(24'h123456, 0, 1, 0, 0, 0, "R1");
    step(24'hF88001, 0, 1, 0, 0, 0, "R1");
    step(24'hF88000, 0, 1, 0, 0, 0, "R1");
    // R2 register access
    step(24'hF88000, 8'hFF, 1, 1, 0, 0, "R2");
    step(24'hF88000, 0, 1, 0, 0, 0, "R2");
    step(24'hF88000, 8'h05, 1, 1, 0, 0, "R2");
    step(24'hF88001, 8'h9E, 1, 1, 0, 0, "R2");
    step(24'hF88001, 0, 1, 0, 0, 0, "R2");
    // R3 translation
    step(24'h001234, 0, 1, 0, 0, 0, "R3");
    step(24'h00F00D, 8'h11, 1, 1, 0, 0, "R3");
    step(24'h1A7FFF, 0, 1, 0, 0, 0, "R3");
    // R5 write protect, R11 latch
    step(24'h00ABCD, 8'h22, 1, 1, 0, 0, "R5");
    step(24'hF88001, 0, 1, 0, 0, 0, "R11");
    step(24'h00ABCD, 0, 1, 0, 0, 0, "R5");
    // R7 execute
    step(24'h018000, 0, 1, 0, 1, 0, "R7");
    step(24'h008000, 0, 1, 0, 1, 0, "R7");
    step(24'hF88001, 0, 1, 0, 0, 0, "R11");
    // R6 invalid, R12 coincidence
    step(24'h010000, 0, 1, 0, 0, 0, "R6");
    step(24'h018000, 0, 1, 0, 0, 0, "R7");
    step(24'h010004, 8'h33, 1, 1, 0, 0, "R12");
    step(24'hF88001, 0, 1, 0, 0, 0, "R12");
    // R4 DMA and idle
    step(24'h00ABCD, 8'h44, 1, 1, 0, 1, "R4");
    step(24'h010000, 0, 1, 0, 1, 1, "R4");
    step(24'h010000, 0, 0, 0, 0, 0, "R4");
    // R9 system mode above RAM
    step(24'hF00000, 8'h55, 1, 1, 0, 0, "R9");
    // R10 abort disabled
    step(24'hF88001, 8'h82, 1, 1, 0, 0, "R10");
    step(24'h008000, 8'h66, 1, 1, 0, 0, "R10");
    step(24'h010000, 0, 1, 0, 0, 0, "R10");
    step(24'hF88001, 0, 1, 0, 0, 0, "R10");
    // R3 other address space
    step(24'hF88000, 8'h06, 1, 1, 0, 0, "R3");
    for (int s = 0; s < 8; s++) step(24'(s * 32768 + 123), 0, 1, 0, 0, 0, "R3");
    // R8 user mode
    step(24'hF88001, 8'h93, 1, 1, 0, 0, "R8");
    step(24'h400000, 0, 1, 0, 0, 0, "R8");
    step(24'hF88000, 8'h01, 1, 1, 0, 0, "R8");
    step(24'h002000, 0, 1, 0, 0, 0, "R8");
    step(24'h7FFFFF, 8'h77, 1, 1, 0, 0, "R8");
    // R4 virtual mode off after a fresh reset
    doReset();
    step(24'h010000, 8'h88, 1, 1, 0, 0, "R4");
    step(24'hF88001, 0, 1, 0, 0, 0, "R1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule